// File: doc/BRIEF.md
# Write-Gathering Memory Command Sequencer

This block connects a 128-bit host-side datapath to a 256-bit, half-rate memory controller port. It pulls commands from a command queue, one at a time. Each command is either a read or a write, selected by a flag. A read goes to the controller as one request and is held until the controller accepts it. A write carries one 128-bit word, taken from a separate write-data queue. Writes are not forwarded one at a time. The block collects four of them, which must sit at rising, adjacent 16-byte addresses starting on a 64-byte boundary. It then sends the gathered 64 bytes as two 256-bit beats, which together fill one memory burst.

Read data coming back from the controller is pushed, in arrival order, into the read-data queue. If a write stream breaks the address rule, or a read arrives while a group is half full, two things happen: the partial group is dropped, and a sticky error flag is raised. The flag clears only on reset.

Top module: `wr_gather_seq`

## Requirements
- R1: A command is accepted (`cmd_ready` high) only while no command is being worked on. While `cmd_ready` is high, neither `mc_read_req` nor `mc_write_req` is asserted.
- R2: A read command (`cmd_is_wr`=0) produces one read request at the command's address. The request stays asserted, with a stable address, until a cycle in which `mc_ready` is high.
- R3: `mc_write_req` stays low until the data words of all four write commands of a group have been taken from the write-data queue.
- R4: A complete group at base address B is sent as two beats. Beat 0 is at address B, with the first word in bits 127:0 and the second word in bits 255:128. Beat 1 is at B+32 and carries the third and fourth words in the same layout. While `mc_ready` stays high, beat 1 is presented in the cycle right after beat 0 is accepted.
- R5: Each write beat is held, with stable address and data, until it is accepted in a cycle with `mc_ready` high.
- R6: The first write of a group must have address bits 5:0 equal to zero. Write k (k=1..3) must be at B+16k. A write that breaks this rule sets `err_seq`. Its data word is consumed and dropped, and the partial group is discarded.
- R7: A read arriving while a group holds one to three words sets `err_seq` and discards those words. The read is still issued.
- R8: `err_seq` stays high once set, even across later valid traffic, until reset.
- R9: `mc_be` is all ones on every write beat.
- R10: A controller read word flagged by `mc_rdata_valid` appears on `rd_data`, with `rd_valid` high, one cycle later, in the same order.
- R11: After reset, `cmd_ready` is high, and `wd_ready`, `mc_read_req`, `mc_write_req`, `rd_valid` and `err_seq` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command queue not empty |
| cmd_ready | output | 1 | Command pop |
| cmd_is_wr | input | 1 | 1 = write, 0 = read |
| cmd_addr | input | AW | Command byte address |
| wd_valid | input | 1 | Write-data queue not empty |
| wd_ready | output | 1 | Write-data pop |
| wd_data | input | NW | Narrow write word |
| mc_ready | input | 1 | Controller can accept a request |
| mc_read_req | output | 1 | Read request |
| mc_write_req | output | 1 | Write beat request |
| mc_addr | output | AW | Request byte address |
| mc_wdata | output | 2*NW | Wide write beat |
| mc_be | output | 2*NW/8 | Write byte enables |
| mc_rdata_valid | input | 1 | Controller read word valid |
| mc_rdata | input | 2*NW | Controller read word |
| rd_valid | output | 1 | Read-data queue push |
| rd_data | output | 2*NW | Read-data queue word |
| err_seq | output | 1 | Sticky ordering error |

## Verification
A mixed command stream drives the gathering logic. It contains:
- aligned four-write groups, which show that words are packed into the correct halves and addresses;
- reads placed between groups, which show that reads pass through unchanged;
- a group broken at its second address, which shows that a partial group is discarded and a fresh group recovers afterwards;
- an unaligned group start;
- a read placed inside a group.

Directed runs then hold `mc_ready` low under a pending read and under each write beat, which separates "held until accepted" from "sent on schedule". A two-word read return shows that ordering is kept.

// File: rtl/wr_gather_seq.sv
module wr_gather_seq #(
  parameter int AW    = 32,
  parameter int NW    = 128,
  parameter int GROUP = 4,
  localparam int WW   = 2 * NW,
  localparam int BEW  = WW / 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_valid,
  output logic          cmd_ready,
  input  logic          cmd_is_wr,
  input  logic [AW-1:0] cmd_addr,
  input  logic          wd_valid,
  output logic          wd_ready,
  input  logic [NW-1:0] wd_data,
  input  logic          mc_ready,
  output logic          mc_read_req,
  output logic          mc_write_req,
  output logic [AW-1:0] mc_addr,
  output logic [WW-1:0] mc_wdata,
  output logic [BEW-1:0] mc_be,
  input  logic          mc_rdata_valid,
  input  logic [WW-1:0] mc_rdata,
  output logic          rd_valid,
  output logic [WW-1:0] rd_data,
  output logic          err_seq
);
  localparam int NB   = NW / 8;
  localparam int WBY  = WW / 8;
  localparam int WB   = GROUP / 2;
  localparam int OFFB = $clog2(GROUP * NB);
  localparam int CW   = $clog2(GROUP);
  localparam int BCW  = (WB > 1) ? $clog2(WB) : 1;

  typedef enum logic [2:0] {S_IDLE, S_DEC, S_RD, S_WDAT, S_DROP, S_WR} st_t;

  st_t           st;
  logic          cw_q;
  logic [AW-1:0] ca_q, base_q;
  logic [CW-1:0] cnt_q;
  logic [BCW-1:0] bq;
  logic [NW-1:0] buf_q [GROUP];
  logic          err_q;

  wire last_word = (cnt_q == CW'(GROUP - 1));
  wire addr_ok   = (cnt_q == '0) ? (ca_q[OFFB-1:0] == '0)
                                 : (ca_q == base_q + AW'(cnt_q) * AW'(NB));

  assign cmd_ready    = (st == S_IDLE);
  assign wd_ready     = (st == S_WDAT) || (st == S_DROP);
  assign mc_read_req  = (st == S_RD);
  assign mc_write_req = (st == S_WR);
  assign mc_addr      = (st == S_WR) ? base_q + AW'(bq) * AW'(WBY) : ca_q;
  assign mc_wdata     = {buf_q[CW'(2 * int'(bq) + 1)], buf_q[CW'(2 * int'(bq))]};
  assign mc_be        = '1;
  assign err_seq      = err_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      cw_q   <= 1'b0;
      ca_q   <= '0;
      base_q <= '0;
      cnt_q  <= '0;
      bq     <= '0;
      err_q  <= 1'b0;
    end else begin
      case (st)
        S_IDLE: if (cmd_valid) begin
          cw_q <= cmd_is_wr;
          ca_q <= cmd_addr;
          st   <= S_DEC;
        end
        S_DEC: begin
          if (!cw_q) begin
            if (cnt_q != '0) begin
              err_q <= 1'b1;
              cnt_q <= '0;
            end
            st <= S_RD;
          end else if (addr_ok) begin
            if (cnt_q == '0) base_q <= ca_q;
            st <= S_WDAT;
          end else begin
            err_q <= 1'b1;
            cnt_q <= '0;
            st    <= S_DROP;
          end
        end
        S_RD: if (mc_ready) st <= S_IDLE;
        S_WDAT: if (wd_valid) begin
          cnt_q <= last_word ? '0 : cnt_q + 1'b1;
          bq    <= '0;
          st    <= last_word ? S_WR : S_IDLE;
        end
        S_DROP: if (wd_valid) st <= S_IDLE;
        S_WR: if (mc_ready) begin
          if (bq == BCW'(WB - 1)) st <= S_IDLE;
          else bq <= bq + 1'b1;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (st == S_WDAT && wd_valid) buf_q[cnt_q] <= wd_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rd_valid <= 1'b0;
    else        rd_valid <= mc_rdata_valid;
  end

  always_ff @(posedge clk) rd_data <= mc_rdata;

  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_ready |-> !(mc_read_req || mc_write_req));

  p_read_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (mc_read_req && !mc_ready) |=> (mc_read_req && $stable(mc_addr)));

  p_no_early_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wd_ready && wd_valid && st == S_WDAT && !last_word) |=> !mc_write_req);

  p_beat_follows_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (mc_write_req && mc_ready && bq == '0) |=>
      (mc_write_req && mc_addr == $past(mc_addr) + AW'(WBY)));

  p_beat_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (mc_write_req && !mc_ready) |=>
      (mc_write_req && $stable(mc_addr) && $stable(mc_wdata)));

  p_group_aligned_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (mc_write_req && bq == '0) |-> (mc_addr[OFFB-1:0] == '0));

  p_err_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    err_seq |=> err_seq);

  p_rdata_order_r10: assert property (@(posedge clk) disable iff (!rst_n)
    mc_rdata_valid |=> (rd_valid && rd_data == $past(mc_rdata)));
endmodule

// File: tb/wr_gather_seq_tb.sv
module wr_gather_seq_tb_top;
  localparam int PERIOD = 10;
  localparam int NV = 22;
  // {is_write, byte address, expected sticky error after the entry}
  localparam logic [33:0] VEC [NV] = '{
    {1'b1, 32'h100, 1'b0}, {1'b1, 32'h110, 1'b0}, {1'b1, 32'h120, 1'b0}, {1'b1, 32'h130, 1'b0},
    {1'b0, 32'h200, 1'b0},
    {1'b1, 32'h1000, 1'b0}, {1'b1, 32'h1010, 1'b0}, {1'b1, 32'h1020, 1'b0}, {1'b1, 32'h1030, 1'b0},
    {1'b1, 32'h040, 1'b0}, {1'b1, 32'h060, 1'b1},
    {1'b1, 32'h080, 1'b1}, {1'b1, 32'h090, 1'b1}, {1'b1, 32'h0A0, 1'b1}, {1'b1, 32'h0B0, 1'b1},
    {1'b1, 32'h008, 1'b1},
    {1'b1, 32'h0C0, 1'b1}, {1'b0, 32'h300, 1'b1},
    {1'b1, 32'h3C0, 1'b1}, {1'b1, 32'h3D0, 1'b1}, {1'b1, 32'h3E0, 1'b1}, {1'b1, 32'h3F0, 1'b1}
  };

  logic clk = 0, rst_n = 0;
  logic cmd_valid = 0, cmd_is_wr = 0, wd_valid = 0, mc_ready = 1, mc_rdata_valid = 0;
  logic [31:0] cmd_addr = 0;
  logic [127:0] wd_data = 0;
  logic [255:0] mc_rdata = 0;
  logic cmd_ready, wd_ready, mc_read_req, mc_write_req, rd_valid, err_seq;
  logic [31:0] mc_addr;
  logic [255:0] mc_wdata, rd_data;
  logic [31:0] mc_be;

  int errs = 0, checks = 0, cyc = 0, obs_n = 0;
  logic        obs_wr [64];
  logic [31:0] obs_addr [64];
  logic [255:0] obs_data [64];
  logic        obs_be [64];
  int          obs_cyc [64];

  wr_gather_seq dut_i (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_is_wr(cmd_is_wr), .cmd_addr(cmd_addr), .wd_valid(wd_valid), .wd_ready(wd_ready),
    .wd_data(wd_data), .mc_ready(mc_ready), .mc_read_req(mc_read_req),
    .mc_write_req(mc_write_req), .mc_addr(mc_addr), .mc_wdata(mc_wdata), .mc_be(mc_be),
    .mc_rdata_valid(mc_rdata_valid), .mc_rdata(mc_rdata), .rd_valid(rd_valid),
    .rd_data(rd_data), .err_seq(err_seq));

  always #(PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    #1;
    if (rst_n && mc_ready && (mc_write_req || mc_read_req) && obs_n < 64) begin
      obs_wr[obs_n] = mc_write_req;
      obs_addr[obs_n] = mc_addr;
      obs_data[obs_n] = mc_write_req ? mc_wdata : '0;
      obs_be[obs_n] = &mc_be;
      obs_cyc[obs_n] = cyc;
      obs_n = obs_n + 1;
    end
  end

  function automatic logic [127:0] dval(input int i);
    return {32'hD00D0000 + 32'(i), 32'(i * 5 + 3), 32'hBEEF0000 ^ 32'(i), 32'(i)};
  endfunction

  task automatic chk(input bit ok, input string req, input logic [255:0] act, input logic [255:0] exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 0;
    tick(3);
    rst_n = 1;
    tick(1);
  endtask

  task automatic push_cmd(input logic w, input logic [31:0] a);
    cmd_valid = 1; cmd_is_wr = w; cmd_addr = a;
    while (!cmd_ready) @(negedge clk);
    @(negedge clk);
    cmd_valid = 0;
  endtask

  task automatic wr_cmd(input logic [31:0] a, input logic [127:0] d);
    push_cmd(1'b1, a);
    wd_valid = 1; wd_data = d;
    while (!wd_ready) @(negedge clk);
    @(negedge clk);
    wd_valid = 0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errs++; checks++;
    $display("FAIL watchdog actual=%0d expected=done", cyc);
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    logic        e_wr [64];
    logic [31:0] e_addr [64];
    logic [255:0] e_data [64];
    logic [127:0] ed [4];
    logic [31:0] ebase;
    int en, ecnt, t0;

    do_reset();
    // R11 / R1 reset state
    chk(cmd_ready === 1'b1, "R11 cmd_ready", 256'(cmd_ready), 256'(1));
    chk({wd_ready, mc_read_req, mc_write_req, rd_valid, err_seq} === 5'b0, "R11 outputs low",
        256'({wd_ready, mc_read_req, mc_write_req, rd_valid, err_seq}), 256'(0));

    // expected transaction list from the requirements
    en = 0; ecnt = 0; ebase = 0;
    for (int i = 0; i < NV; i++) begin
      logic w; logic [31:0] a;
      w = VEC[i][33]; a = VEC[i][32:1];
      if (!w) begin
        ecnt = 0;
        e_wr[en] = 0; e_addr[en] = a; e_data[en] = '0; en++;
      end else if ((ecnt == 0 && a[5:0] == 0) || (ecnt != 0 && a == ebase + 32'(16 * ecnt))) begin
        if (ecnt == 0) ebase = a;
        ed[ecnt] = dval(i);
        ecnt++;
        if (ecnt == 4) begin
          e_wr[en] = 1; e_addr[en] = ebase; e_data[en] = {ed[1], ed[0]}; en++;
          e_wr[en] = 1; e_addr[en] = ebase + 32; e_data[en] = {ed[3], ed[2]}; en++;
          ecnt = 0;
        end
      end else ecnt = 0;
    end

    t0 = obs_n;
    for (int i = 0; i < NV; i++) begin
      if (VEC[i][33]) wr_cmd(VEC[i][32:1], dval(i));
      else push_cmd(1'b0, VEC[i][32:1]);
      tick(3);
      chk(err_seq === VEC[i][0], $sformatf("R6/R7/R8 err after entry %0d", i),
          256'(err_seq), 256'(VEC[i][0]));
    end
    tick(4);
    chk(obs_n - t0 == en, "R3 transaction count", 256'(obs_n - t0), 256'(en));
    for (int k = 0; k < en && t0 + k < obs_n; k++) begin
      chk(obs_wr[t0+k] === e_wr[k], $sformatf("R2/R4 kind %0d", k), 256'(obs_wr[t0+k]), 256'(e_wr[k]));
      chk(obs_addr[t0+k] === e_addr[k], $sformatf("R2/R4 addr %0d", k), 256'(obs_addr[t0+k]), 256'(e_addr[k]));
      if (e_wr[k]) begin
        chk(obs_data[t0+k] === e_data[k], $sformatf("R4 data %0d", k), obs_data[t0+k], e_data[k]);
        chk(obs_be[t0+k] === 1'b1, $sformatf("R9 be %0d", k), 256'(obs_be[t0+k]), 256'(1));
        if (k > 0 && e_addr[k][5] && e_wr[k-1])
          chk(obs_cyc[t0+k] == obs_cyc[t0+k-1] + 1, "R4 consecutive beats",
              256'(obs_cyc[t0+k]), 256'(obs_cyc[t0+k-1] + 1));
      end
    end

    // R2: read held while controller busy
    do_reset();
    mc_ready = 0;
    push_cmd(1'b0, 32'h500);
    tick(4);
    chk(mc_read_req === 1'b1 && mc_addr === 32'h500, "R2 read held", 256'(mc_addr), 256'(32'h500));
    chk(cmd_ready === 1'b0, "R1 busy no accept", 256'(cmd_ready), 256'(0));
    mc_ready = 1;
    tick(1);
    chk(mc_read_req === 1'b0, "R2 read released", 256'(mc_read_req), 256'(0));

    // R3 / R5 / R4: write back-pressure
    mc_ready = 0;
    for (int k = 0; k < 3; k++) wr_cmd(32'h600 + 32'(16 * k), dval(200 + k));
    tick(2);
    chk(mc_write_req === 1'b0, "R3 no write before four words", 256'(mc_write_req), 256'(0));
    wr_cmd(32'h630, dval(203));
    chk(mc_write_req === 1'b1 && mc_addr === 32'h600, "R5 beat0 presented", 256'(mc_addr), 256'(32'h600));
    tick(2);
    chk(mc_write_req === 1'b1 && mc_wdata === {dval(201), dval(200)}, "R5 beat0 held",
        mc_wdata, {dval(201), dval(200)});
    mc_ready = 1;
    tick(1);
    chk(mc_addr === 32'h620 && mc_wdata === {dval(203), dval(202)}, "R4 beat1 next cycle",
        mc_wdata, {dval(203), dval(202)});
    mc_ready = 0;
    tick(2);
    chk(mc_write_req === 1'b1 && mc_addr === 32'h620, "R5 beat1 held", 256'(mc_addr), 256'(32'h620));
    mc_ready = 1;
    tick(1);
    chk(mc_write_req === 1'b0 && cmd_ready === 1'b1, "R1 back to idle", 256'(mc_write_req), 256'(0));
    chk(err_seq === 1'b0, "R8 no error on clean traffic", 256'(err_seq), 256'(0));

    // R6 unaligned start, then R8 stickiness
    do_reset();
    t0 = obs_n;
    wr_cmd(32'h608, dval(300));
    tick(3);
    chk(err_seq === 1'b1, "R6 unaligned start", 256'(err_seq), 256'(1));
    chk(obs_n == t0, "R6 nothing issued", 256'(obs_n - t0), 256'(0));
    for (int k = 0; k < 4; k++) wr_cmd(32'h700 + 32'(16 * k), dval(310 + k));
    tick(4);
    chk(obs_n == t0 + 2, "R8 later group issued", 256'(obs_n - t0), 256'(2));
    chk(err_seq === 1'b1, "R8 error sticky", 256'(err_seq), 256'(1));
    do_reset();
    chk(err_seq === 1'b0, "R8 cleared by reset", 256'(err_seq), 256'(0));

    // R7 read inside a group
    t0 = obs_n;
    wr_cmd(32'h800, dval(400));
    push_cmd(1'b0, 32'h900);
    tick(4);
    chk(err_seq === 1'b1, "R7 error on read mid-group", 256'(err_seq), 256'(1));
    chk(obs_n == t0 + 1 && obs_wr[t0] === 1'b0 && obs_addr[t0] === 32'h900, "R7 read issued",
        256'(obs_addr[t0]), 256'(32'h900));
    for (int k = 0; k < 4; k++) wr_cmd(32'hA00 + 32'(16 * k), dval(410 + k));
    tick(4);
    chk(obs_n == t0 + 3 && obs_data[t0+1] === {dval(411), dval(410)}, "R7 partial discarded",
        obs_data[t0+1], {dval(411), dval(410)});

    // R10 read return ordering
    mc_rdata_valid = 1; mc_rdata = {8{32'h11110000}};
    tick(1);
    chk(rd_valid === 1'b1 && rd_data === {8{32'h11110000}}, "R10 first word", rd_data, {8{32'h11110000}});
    mc_rdata = {8{32'h22220000}};
    tick(1);
    chk(rd_valid === 1'b1 && rd_data === {8{32'h22220000}}, "R10 second word", rd_data, {8{32'h22220000}});
    mc_rdata_valid = 0;
    tick(1);
    chk(rd_valid === 1'b0, "R10 valid drops", 256'(rd_valid), 256'(0));

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule